// File: doc/BRIEF.md
# Multiword DMA engine for a parallel storage port

This block moves 16-bit words between a memory-side streaming interface and a parallel storage device. It runs one transfer at a time using the request/acknowledge handshake (device raises DMARQ, engine answers with DMACK and then pulses a read or write strobe once per word). Software sets up a transfer by writing a configuration register that holds the enable, the direction, the byte-swap and endian bits, a stop-on-request-drop bit, a 20-bit word count and a start address. A timing register sets the length of every handshake phase. When the transfer ends the engine clears its enable and raises a done flag. That flag is cleared by writing one to it, and it drives an interrupt through an enable mask.

The word count is loaded as "words minus one" and counts down once per word moved. After a complete transfer it reads all ones, so any other value after a stop shows an early end. Chaining several buffers is left to software, which reprograms the engine for each segment.

Top module: `pstor_dma`

## Requirements
- R1: Registers sit at byte offsets 0x00 (config), 0x20 (timing), 0x38 (status, bit 0 = done) and 0x50 (interrupt enable, bit 0). Config bits: [0] enable, [1] direction (1 = memory to device), [2] swap, [3] endian, [4] stop-on-drop, [27:8] word count, [63:32] address. After reset config reads 0x0FFFFF00. Every written field reads back.
- R2: The word count holds words-1, drops by one per word moved, and reads 0xFFFFF after a complete transfer.
- R3: At the end of a transfer the enable bit reads 0 and done reads 1. Writing 1 to status bit 0 clears done, and writing 0 leaves it set.
- R4: The interrupt output is high exactly when done and the interrupt enable are both 1.
- R5: With direction 0, device words appear on the output stream in order, each at an address 2 above the previous one, starting at the programmed address. With direction 1, input stream words are driven to the device in order.
- R6: With swap 1, the two bytes of every word are exchanged in both directions.
- R7: Timing fields are 6 bits each at [5:0] setup, [11:6] read active, [17:12] read negated, [23:18] write active, [29:24] write negated, [35:30] hold, [41:36] request delay, [47:42] pause. A field F spans (F+1)*4 clocks. A strobe stays high for (active+1)*4 clocks. With the stream ready, the low gap between strobes is (negated+1)*4+1 clocks.
- R8: DMACK is active for (setup+1)*4+1 clocks before the first strobe. Timing bit 48 inverts the DMACK output, including while idle.
- R9: The request delay counts raw clocks. DMACK is not raised until DMARQ has been high on delay+1 consecutive clocks, so a shorter pulse is ignored.
- R10: With stop-on-drop 0, a DMARQ drop between words halts the strobes while DMACK stays active. The transfer resumes and completes when DMARQ returns.
- R11: With stop-on-drop 1, a DMARQ drop between words ends the transfer and sets done. The count then reads words-1 minus the number of words moved.
- R12: Writing config with enable 0 and count 0xFFFFF stops the engine. On the next clock DMACK and both strobes are inactive, and done is not set.
- R13: A stream that is not ready (input valid low, or output ready low) stalls the transfer without losing, repeating or reordering words. An offered output word stays stable until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr |
| irq | output | 1 | Interrupt: done and enabled |
| s_tvalid | input | 1 | Input stream word valid (memory to device) |
| s_tready | output | 1 | Input stream word accepted |
| s_tdata | input | 16 | Input stream word |
| m_tvalid | output | 1 | Output stream word valid (device to memory) |
| m_tready | input | 1 | Output stream ready |
| m_tdata | output | 16 | Output stream word |
| mem_addr | output | 32 | Current memory byte address |
| dev_dmarq | input | 1 | Device DMA request |
| dev_dmack | output | 1 | DMA acknowledge, polarity programmable |
| dev_dior | output | 1 | Read strobe, active high |
| dev_diow | output | 1 | Write strobe, active high |
| dev_din | input | 16 | Data from device |
| dev_dout | output | 16 | Data to device |
| dev_doe | output | 1 | Output enable for dev_dout |

## Verification
The engine runs device-to-memory transfers with an always-ready stream, where the strobe widths, the gaps and the acknowledge lead are measured against the timing formulas. It also runs them with a stream that stalls in a fixed pattern, which exposes any lost or doubled word and any address step that is not tied to the handshake. A memory-to-device transfer with swap on and a starved input stream separates the write path and its timing fields from the read ones. Request-line patterns follow: a pulse shorter than the delay, a drop in pause mode, a drop in stop mode and a software stop mid-transfer. These separate a pause from an early end from an abort, using the count readback and the done flag.

// File: rtl/pstor_dma_pkg.sv
package pstor_dma_pkg;
    typedef enum logic [2:0] {
        PH_IDLE, PH_WRQ, PH_SETUP, PH_GATE, PH_ACT, PH_NEG, PH_HOLD, PH_PAUSE
    } phase_e;

    localparam logic [7:0] OFF_CFG  = 8'h00;
    localparam logic [7:0] OFF_TIM  = 8'h20;
    localparam logic [7:0] OFF_STAT = 8'h38;
    localparam logic [7:0] OFF_IEN  = 8'h50;

    // timing field slots, each TF_W bits wide
    localparam int FLD_SETUP = 0;
    localparam int FLD_RACT  = 1;
    localparam int FLD_RNEG  = 2;
    localparam int FLD_WACT  = 3;
    localparam int FLD_WNEG  = 4;
    localparam int FLD_HOLD  = 5;
    localparam int FLD_RQDLY = 6;
    localparam int FLD_PAUSE = 7;
    localparam int NUM_FLD   = 8;
endpackage

// File: rtl/pstor_dma_swap.sv
module pstor_dma_swap #(
    parameter int WORD_W = 16
) (
    input  logic              sw,
    input  logic [WORD_W-1:0] x,
    output logic [WORD_W-1:0] y
);
    localparam int BYTES = WORD_W / 8;
    logic [WORD_W-1:0] rev;

    // reverse byte lanes
    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign rev[b*8 +: 8] = x[(BYTES-1-b)*8 +: 8];
    end

    assign y = sw ? rev : x;
endmodule

// File: rtl/pstor_dma_rqq.sv
module pstor_dma_rqq #(
    parameter int TF_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic            dmarq,
    input  logic [TF_W-1:0] dly,
    output logic            ok
);
    logic [TF_W-1:0] run_d, run_q;

    // count consecutive high samples of the request, in raw clocks
    always_comb begin
        run_d = '0;
        if (arm && dmarq) begin
            run_d = (run_q == dly) ? run_q : run_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    assign ok = arm && dmarq && (run_q == dly);
endmodule

// File: rtl/pstor_dma.sv
module pstor_dma
    import pstor_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 20,
    parameter int TF_W   = 6,
    parameter int MULT   = 4,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    output logic              irq,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic [WORD_W-1:0] s_tdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [WORD_W-1:0] m_tdata,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              dev_dmarq,
    output logic              dev_dmack,
    output logic              dev_dior,
    output logic              dev_diow,
    input  logic [WORD_W-1:0] dev_din,
    output logic [WORD_W-1:0] dev_dout,
    output logic              dev_doe
);
    localparam int TIM_W   = NUM_FLD * TF_W + 1;
    localparam int POL_BIT = NUM_FLD * TF_W;
    localparam int CNT_W   = TF_W + $clog2(MULT) + 1;
    localparam int SIZE_LO = 8;
    localparam int ADDR_LO = 32;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);

    typedef struct packed {
        phase_e             ph;
        logic [CNT_W-1:0]   cnt;
        logic               en;
        logic               dir;
        logic               swap;
        logic               endian;
        logic               sod;
        logic [SIZE_W-1:0]  size;
        logic [ADDR_W-1:0]  addr;
        logic [TIM_W-1:0]   tim;
        logic               done;
        logic               ien;
        logic [WORD_W-1:0]  dout;
        logic [WORD_W-1:0]  obuf;
        logic               ov;
    } state_t;

    state_t q, d;

    logic              cfg_hit, tim_hit, stat_hit, ien_hit;
    logic              rq_ok, pop, ack_act;
    logic [WORD_W-1:0] wr_word, rd_word;
    logic              en_w, done_w;
    logic [SIZE_W-1:0] size_w;
    logic              unused_bits;

    // phase length in clocks minus one: (field + 1) * MULT - 1
    function automatic logic [CNT_W-1:0] span(input logic [TIM_W-1:0] t, input int idx);
        logic [CNT_W-1:0] f;
        f = CNT_W'(t[idx*TF_W +: TF_W]);
        return (f + 1'b1) * CNT_W'(MULT) - 1'b1;
    endfunction

    assign cfg_hit  = reg_we && (reg_addr == OFF_CFG);
    assign tim_hit  = reg_we && (reg_addr == OFF_TIM);
    assign stat_hit = reg_we && (reg_addr == OFF_STAT);
    assign ien_hit  = reg_we && (reg_addr == OFF_IEN);
    assign pop      = q.ov && m_tready;

    pstor_dma_rqq #(.TF_W(TF_W)) u_rqq (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (q.ph == PH_WRQ),
        .dmarq (dev_dmarq),
        .dly   (q.tim[FLD_RQDLY*TF_W +: TF_W]),
        .ok    (rq_ok)
    );

    pstor_dma_swap #(.WORD_W(WORD_W)) u_swap_wr (
        .sw (q.swap),
        .x  (s_tdata),
        .y  (wr_word)
    );

    pstor_dma_swap #(.WORD_W(WORD_W)) u_swap_rd (
        .sw (q.swap),
        .x  (dev_din),
        .y  (rd_word)
    );

    always_comb begin
        d = q;
        if (tim_hit) d.tim = reg_wdata[TIM_W-1:0];
        if (ien_hit) d.ien = reg_wdata[0];
        if (stat_hit && reg_wdata[0]) d.done = 1'b0;
        if (pop) begin
            d.ov   = 1'b0;
            d.addr = q.addr + STEP;
        end
        if (q.cnt != '0) d.cnt = q.cnt - 1'b1;

        case (q.ph)
            PH_IDLE: begin
                if (q.en) d.ph = PH_WRQ;
            end
            PH_WRQ: begin
                if (rq_ok) begin
                    d.ph  = PH_SETUP;
                    d.cnt = span(q.tim, FLD_SETUP);
                end
            end
            PH_SETUP: begin
                if (q.cnt == '0) d.ph = PH_GATE;
            end
            PH_GATE: begin
                if (!dev_dmarq) begin
                    if (q.sod) begin
                        d.ph  = PH_HOLD;
                        d.cnt = span(q.tim, FLD_HOLD);
                    end
                end else if (q.dir && s_tvalid) begin
                    d.ph   = PH_ACT;
                    d.cnt  = span(q.tim, FLD_WACT);
                    d.dout = wr_word;
                    d.addr = q.addr + STEP;
                end else if (!q.dir && !q.ov) begin
                    d.ph  = PH_ACT;
                    d.cnt = span(q.tim, FLD_RACT);
                end
            end
            PH_ACT: begin
                if (q.cnt == '0) begin
                    if (!q.dir) begin
                        d.obuf = rd_word;
                        d.ov   = 1'b1;
                    end
                    d.size = q.size - 1'b1;
                    d.ph   = PH_NEG;
                    d.cnt  = span(q.tim, q.dir ? FLD_WNEG : FLD_RNEG);
                end
            end
            PH_NEG: begin
                if (q.cnt == '0) begin
                    if (&q.size) begin
                        d.ph  = PH_HOLD;
                        d.cnt = span(q.tim, FLD_HOLD);
                    end else begin
                        d.ph = PH_GATE;
                    end
                end
            end
            PH_HOLD: begin
                if (q.cnt == '0) begin
                    d.ph  = PH_PAUSE;
                    d.cnt = span(q.tim, FLD_PAUSE);
                end
            end
            PH_PAUSE: begin
                if (q.cnt == '0 && !q.ov) begin
                    d.ph   = PH_IDLE;
                    d.en   = 1'b0;
                    d.done = 1'b1;
                end
            end
            default: d.ph = PH_IDLE;
        endcase

        // a config write always restarts from idle
        if (cfg_hit) begin
            d.ph     = PH_IDLE;
            d.cnt    = '0;
            d.ov     = 1'b0;
            d.en     = reg_wdata[0];
            d.dir    = reg_wdata[1];
            d.swap   = reg_wdata[2];
            d.endian = reg_wdata[3];
            d.sod    = reg_wdata[4];
            d.size   = reg_wdata[SIZE_LO +: SIZE_W];
            d.addr   = reg_wdata[ADDR_LO +: ADDR_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.size <= '1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_CFG: begin
                reg_rdata[0]                 = q.en;
                reg_rdata[1]                 = q.dir;
                reg_rdata[2]                 = q.swap;
                reg_rdata[3]                 = q.endian;
                reg_rdata[4]                 = q.sod;
                reg_rdata[SIZE_LO +: SIZE_W] = q.size;
                reg_rdata[ADDR_LO +: ADDR_W] = q.addr;
            end
            OFF_TIM:  reg_rdata[TIM_W-1:0] = q.tim;
            OFF_STAT: reg_rdata[0] = q.done;
            OFF_IEN:  reg_rdata[0] = q.ien;
            default:  reg_rdata = '0;
        endcase
    end

    assign ack_act = (q.ph == PH_SETUP) || (q.ph == PH_GATE) || (q.ph == PH_ACT) ||
                     (q.ph == PH_NEG)   || (q.ph == PH_HOLD);

    assign dev_dmack = ack_act ^ q.tim[POL_BIT];
    assign dev_dior  = (q.ph == PH_ACT) && !q.dir;
    assign dev_diow  = (q.ph == PH_ACT) && q.dir;
    assign dev_dout  = q.dout;
    assign dev_doe   = ack_act && q.dir;
    assign s_tready  = (q.ph == PH_GATE) && dev_dmarq && q.dir;
    assign m_tvalid  = q.ov;
    assign m_tdata   = q.obuf;
    assign mem_addr  = q.addr;
    assign irq       = q.done && q.ien;

    assign en_w   = q.en;
    assign done_w = q.done;
    assign size_w = q.size;

    assign unused_bits = &{1'b0, reg_wdata};
endmodule

// File: rtl/pstor_dma_chk.sv
module pstor_dma_chk #(
    parameter int SIZE_W = 20,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dior,
    input logic              diow,
    input logic              ack,
    input logic              en,
    input logic              done,
    input logic [SIZE_W-1:0] size,
    input logic              cfg_wr,
    input logic              m_tvalid,
    input logic              m_tready,
    input logic [WORD_W-1:0] m_tdata
);
    localparam logic [SIZE_W-1:0] ONE = {{(SIZE_W-1){1'b0}}, 1'b1};

    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(dior && diow)); // R5

    AST_STROBE_UNDER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (dior || diow) |-> ack); // R8

    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !en); // R3

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dior || diow) && !$past(cfg_wr)) |-> (size == $past(size) - ONE)); // R2

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready && !cfg_wr) |=> (m_tvalid && $stable(m_tdata))); // R13

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !(dior || diow)); // R12
endmodule

bind pstor_dma pstor_dma_chk #(.SIZE_W(SIZE_W), .WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dior     (dev_dior),
    .diow     (dev_diow),
    .ack      (ack_act),
    .en       (en_w),
    .done     (done_w),
    .size     (size_w),
    .cfg_wr   (cfg_hit),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tdata  (m_tdata)
);

// File: tb/sim_pstor_dma.sv
module sim_pstor_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        irq;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic [15:0] s_tdata = '0;
    logic        m_tvalid;
    logic        m_tready = 1'b1;
    logic [15:0] m_tdata;
    logic [31:0] mem_addr;
    logic        dev_dmarq;
    logic        dev_dmack, dev_dior, dev_diow, dev_doe;
    logic [15:0] dev_din = '0;
    logic [15:0] dev_dout;

    int tests = 0, fails = 0;
    bit finished = 0;

    // stimulus controls
    bit dmarq_on = 0, resume = 0, pol_tb = 0, s_stall = 0, m_stall = 0;
    int drop_at = 0;
    int falls = 0, rd_idx = 0, s_idx = 0, cyc = 0;
    logic [15:0] dev_src[$], dev_sink[$], msrc[$], mem_d[$];
    logic [31:0] mem_a[$];
    int wid_q[$], gap_q[$], su_q[$];

    assign dev_dmarq = dmarq_on && !(drop_at != 0 && falls >= drop_at && !resume);

    always #5 clk = ~clk;

    pstor_dma u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
        .mem_addr(mem_addr), .dev_dmarq(dev_dmarq), .dev_dmack(dev_dmack),
        .dev_dior(dev_dior), .dev_diow(dev_diow), .dev_din(dev_din),
        .dev_dout(dev_dout), .dev_doe(dev_doe)
    );

    // handshakes complete at the clock edge
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (s_tvalid && s_tready) s_idx <= s_idx + 1;
        if (m_tvalid && m_tready) begin
            mem_d.push_back(m_tdata);
            mem_a.push_back(mem_addr);
        end
    end

    // stream drivers and device model, away from the active edge
    bit prev_s = 0, prev_w = 0, seen = 0;
    int hi = 0, lo = 0, su = 0;
    always @(negedge clk) begin
        m_tready = !m_stall || (cyc % 5 < 2);
        s_tvalid = (s_idx < msrc.size()) && (!s_stall || (cyc % 3 == 0));
        s_tdata  = (s_idx < msrc.size()) ? msrc[s_idx] : 16'h0;
        if (dev_dior && !prev_s) begin
            dev_din = (rd_idx < dev_src.size()) ? dev_src[rd_idx] : 16'h0;
            rd_idx++;
        end
        if (prev_w && !dev_diow) dev_sink.push_back(dev_dout);
        if (prev_s && !(dev_dior || dev_diow)) falls++;
        if ((dev_dmack ^ pol_tb) == 1'b0) begin
            seen = 0; hi = 0; lo = 0; su = 0;
        end else if (dev_dior || dev_diow) begin
            if (!prev_s) begin
                if (!seen) su_q.push_back(su); else gap_q.push_back(lo);
                seen = 1; hi = 1;
            end else hi++;
        end else begin
            if (prev_s) begin wid_q.push_back(hi); lo = 1; end
            else if (seen) lo++;
            else su++;
        end
        prev_s = dev_dior || dev_diow;
        prev_w = dev_diow;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_done(output bit got);
        logic [63:0] v;
        got = 0;
        for (int i = 0; i < 4000 && !got; i++) begin
            rd(8'h38, v);
            got = v[0];
        end
    endtask

    function automatic logic [63:0] mk_tim(int s, int ra, int rn, int wa, int wn, int h, int dl, int p, bit pol);
        return {15'd0, pol, 6'(p), 6'(dl), 6'(h), 6'(wn), 6'(wa), 6'(rn), 6'(ra), 6'(s)};
    endfunction

    function automatic logic [63:0] mk_cfg(bit en, bit dir, bit sw, bit endian, bit sod, int sz, logic [31:0] a);
        return {a, 4'd0, 20'(sz), 3'd0, sod, endian, sw, dir, en};
    endfunction

    function automatic logic [15:0] sw16(logic [15:0] w);
        return {w[7:0], w[15:8]};
    endfunction

    function automatic logic [15:0] wgen(int i);
        return 16'hA500 ^ 16'(i * 37 + 3);
    endfunction

    // device-to-memory run: checks data, addresses and count readback
    task automatic run_read(input int n, input bit sw, input logic [31:0] base, input string req);
        int st, ms;
        bit got;
        logic [63:0] v;
        st = rd_idx; ms = mem_d.size();
        while (dev_src.size() < st + n) dev_src.push_back(wgen(dev_src.size()));
        wr(8'h00, mk_cfg(1, 0, sw, 0, 0, n - 1, base));
        wait_done(got);
        chk(got, "R3 done after read run", got, 1);
        chk(mem_d.size() - ms == n, {req, " word count"}, mem_d.size() - ms, n);
        for (int i = 0; i < n && ms + i < mem_d.size(); i++) begin
            logic [15:0] e;
            e = sw ? sw16(dev_src[st + i]) : dev_src[st + i];
            chk(mem_d[ms + i] == e, {req, " read data"}, mem_d[ms + i], e);
            chk(mem_a[ms + i] == base + 2 * i, "R5 address step", mem_a[ms + i], base + 2 * i);
        end
        rd(8'h00, v);
        chk(v[27:8] == 20'hFFFFF, "R2 count after full run", v[27:8], 20'hFFFFF);
        chk(v[0] == 1'b0, "R3 enable cleared", v[0], 0);
    endtask

    logic [63:0] v;
    bit got;
    int base_f, ms, ds;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(irq == 0, "R4 reset irq", irq, 0);
        chk(dev_dmack == 0 && dev_dior == 0 && dev_diow == 0, "R8 reset device pins",
            {dev_dmack, dev_dior, dev_diow}, 0);
        rd(8'h00, v);
        chk(v == 64'h0FFFFF00, "R1 reset config", v, 64'h0FFFFF00);

        // register readback
        wr(8'h20, mk_tim(1, 2, 1, 3, 0, 1, 2, 0, 0));
        rd(8'h20, v);
        chk(v == mk_tim(1, 2, 1, 3, 0, 1, 2, 0, 0), "R1 timing readback", v, mk_tim(1, 2, 1, 3, 0, 1, 2, 0, 0));
        wr(8'h00, mk_cfg(0, 1, 1, 1, 1, 20'h12345, 32'hCAFE0010));
        rd(8'h00, v);
        chk(v == mk_cfg(0, 1, 1, 1, 1, 20'h12345, 32'hCAFE0010), "R1 config readback",
            v, mk_cfg(0, 1, 1, 1, 1, 20'h12345, 32'hCAFE0010));

        // plain read run, ready stream
        dmarq_on = 1;
        wid_q.delete(); gap_q.delete(); su_q.delete();
        run_read(6, 0, 32'h0000_1000, "R5");
        chk(su_q.size() == 1 && su_q[0] == 9, "R8 ack lead", su_q.size() > 0 ? su_q[0] : -1, 9);
        foreach (wid_q[i]) chk(wid_q[i] == 12, "R7 read strobe width", wid_q[i], 12);
        foreach (gap_q[i]) chk(gap_q[i] == 9, "R7 read strobe gap", gap_q[i], 9);
        chk(wid_q.size() == 6, "R7 strobe count", wid_q.size(), 6);

        // done / interrupt
        chk(irq == 0, "R4 irq masked", irq, 0);
        wr(8'h50, 64'h1);
        @(negedge clk);
        chk(irq == 1, "R4 irq when enabled", irq, 1);
        wr(8'h38, 64'h0);
        rd(8'h38, v);
        chk(v[0] == 1, "R3 write zero keeps done", v[0], 1);
        wr(8'h38, 64'h1);
        rd(8'h38, v);
        chk(v[0] == 0 && irq == 0, "R3 write one clears done", {v[0], irq}, 0);

        // write run with swap and starved input stream
        s_stall = 1;
        wid_q.delete();
        ds = dev_sink.size();
        begin
            int st;
            st = msrc.size();
            for (int i = 0; i < 5; i++) msrc.push_back(16'h1200 + 16'(i * 257));
            wr(8'h00, mk_cfg(1, 1, 1, 0, 0, 4, 32'h0000_2000));
            wait_done(got);
            chk(got, "R3 done after write run", got, 1);
            chk(dev_sink.size() - ds == 5, "R5 write word count", dev_sink.size() - ds, 5);
            for (int i = 0; i < 5 && ds + i < dev_sink.size(); i++)
                chk(dev_sink[ds + i] == sw16(msrc[st + i]), "R6 R13 write data swapped",
                    dev_sink[ds + i], sw16(msrc[st + i]));
            foreach (wid_q[i]) chk(wid_q[i] == 16, "R7 write strobe width", wid_q[i], 16);
            rd(8'h00, v);
            chk(v[63:32] == 32'h0000_200A, "R5 write address", v[63:32], 32'h0000_200A);
        end
        s_stall = 0;
        wr(8'h38, 64'h1);

        // read run with stalling output stream and swap
        m_stall = 1;
        run_read(8, 1, 32'h0000_3000, "R13 R6");
        m_stall = 0;
        wr(8'h38, 64'h1);

        // acknowledge polarity
        wr(8'h20, mk_tim(1, 2, 1, 3, 0, 1, 2, 0, 1));
        pol_tb = 1;
        @(negedge clk);
        chk(dev_dmack == 1, "R8 inverted idle ack", dev_dmack, 1);
        wr(8'h20, mk_tim(1, 2, 1, 3, 0, 1, 5, 0, 0));
        pol_tb = 0;
        @(negedge clk);
        chk(dev_dmack == 0, "R8 normal idle ack", dev_dmack, 0);

        // request delay of 5 raw clocks: a 3-clock pulse is ignored
        dmarq_on = 0;
        ms = mem_d.size();
        while (dev_src.size() < rd_idx + 2) dev_src.push_back(wgen(dev_src.size()));
        wr(8'h00, mk_cfg(1, 0, 0, 0, 0, 1, 32'h0000_4000));
        @(negedge clk); dmarq_on = 1;
        repeat (3) @(negedge clk);
        dmarq_on = 0;
        repeat (10) @(negedge clk);
        chk(dev_dmack == 0, "R9 short request ignored", dev_dmack, 0);
        dmarq_on = 1;
        wait_done(got);
        chk(got && mem_d.size() - ms == 2, "R9 run after steady request", mem_d.size() - ms, 2);
        wr(8'h38, 64'h1);
        wr(8'h20, mk_tim(1, 2, 1, 3, 0, 1, 2, 0, 0));

        // pause mode: drop after 2 words
        base_f = falls; resume = 0; drop_at = base_f + 2;
        ms = mem_d.size();
        while (dev_src.size() < rd_idx + 6) dev_src.push_back(wgen(dev_src.size()));
        wr(8'h00, mk_cfg(1, 0, 0, 0, 0, 5, 32'h0000_5000));
        for (int i = 0; i < 400 && falls < drop_at; i++) @(negedge clk);
        repeat (60) @(negedge clk);
        chk(falls - base_f == 2, "R10 strobes halt on drop", falls - base_f, 2);
        chk(dev_dmack == 1, "R10 ack held while paused", dev_dmack, 1);
        resume = 1;
        wait_done(got);
        chk(mem_d.size() - ms == 6, "R10 resumed run completes", mem_d.size() - ms, 6);
        rd(8'h00, v);
        chk(v[27:8] == 20'hFFFFF, "R10 R2 full count after pause", v[27:8], 20'hFFFFF);
        drop_at = 0; resume = 0;
        wr(8'h38, 64'h1);

        // stop mode: drop after 3 of 8 words
        base_f = falls; drop_at = base_f + 3;
        ms = mem_d.size();
        while (dev_src.size() < rd_idx + 8) dev_src.push_back(wgen(dev_src.size()));
        wr(8'h00, mk_cfg(1, 0, 0, 0, 1, 7, 32'h0000_6000));
        wait_done(got);
        chk(got, "R11 done on early end", got, 1);
        rd(8'h00, v);
        chk(v[27:8] == 20'd4, "R11 remaining count", v[27:8], 4);
        chk(mem_d.size() - ms == 3, "R11 words moved", mem_d.size() - ms, 3);
        drop_at = 0;
        wr(8'h38, 64'h1);

        // software stop mid-transfer
        base_f = falls;
        while (dev_src.size() < rd_idx + 100) dev_src.push_back(wgen(dev_src.size()));
        wr(8'h00, mk_cfg(1, 0, 0, 0, 0, 99, 32'h0000_7000));
        for (int i = 0; i < 400 && falls < base_f + 4; i++) @(negedge clk);
        repeat (5) @(negedge clk);
        wr(8'h00, mk_cfg(0, 0, 0, 0, 0, 20'hFFFFF, 32'h0));
        chk(dev_dmack == 0 && dev_dior == 0 && dev_diow == 0, "R12 pins idle after stop",
            {dev_dmack, dev_dior, dev_diow}, 0);
        repeat (20) @(negedge clk);
        rd(8'h38, v);
        chk(v[0] == 0, "R12 no done after stop", v[0], 0);
        rd(8'h00, v);
        chk(v[27:0] == 28'hFFFFF00, "R12 idle config after stop", v[27:0], 28'hFFFFF00);

        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1;
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule